// File: doc/BRIEF.md
# Three-Port Bus Crossbar with Per-Slave Priority Arbiters

This block joins three bus masters to three slave targets so that each master can reach any target through one switch. The masters are an instruction fetch port, a data load/store port and a DMA engine. The targets are a code/data memory, an SRAM and a peripheral bridge. Each master presents a 32-bit address, a write flag and 32-bit write data, and holds that request steady until it is acknowledged. The upper address nibble selects the target. An address outside the three windows is answered with an error acknowledge and reaches no target.

Every target has its own arbiter. When several masters want the same target in the same cycle, the arbiter grants the highest-ranked one. The ranking is data port first, then instruction port, then DMA. Any master can drive its boost sideband to jump ahead of unboosted masters. Among boosted masters the same base ranking applies. A grant lasts for exactly one transfer. Masters that go to different targets are served in parallel.

Master vectors use index 0 for the data port, 1 for the instruction port and 2 for DMA. Target vectors use index 0 for code/data memory, 1 for SRAM and 2 for the peripheral bridge. Wide buses are packed with entry `i` at bits `[i*32 +: 32]`.

Top module: `xbar3_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, every `s_valid` bit and every `m_ack` bit is 0.
- R2: Address bits [31:28] pick the target: 4'h0 selects target 0, 4'h4 selects target 1 and 4'hC selects target 2. While a target's `s_valid` is high, its `s_addr`, `s_we` and `s_wdata` equal the owning master's `m_addr`, `m_we` and `m_wdata`.
- R3: A request whose bits [31:28] match none of the windows gets `m_ack` and `m_err` high together, in the second cycle the request is seen. No target asserts `s_valid` for it.
- R4: With no boosted contender, an idle target grants the lowest-index requester. Index 0 (data) beats index 1 (instruction), which beats index 2 (DMA).
- R5: If any contender for an idle target has `m_boost` high, the grant goes to a boosted contender. Among boosted contenders the lowest index wins.
- R6: Once a target is granted, its owner and forwarded request stay unchanged until the target returns `s_ready`. A contender that lost keeps `m_ack` low for that whole time.
- R7: Masters that target different slaves are granted in the same cycle, and no master is routed to more than one target at a time.
- R8: `m_ack` of a master rises only in the cycle in which the target it owns has both `s_valid` and `s_ready` high. In that cycle `m_rdata` equals that target's `s_rdata` and `m_err` is 0.
- R9: An idle target with a request pending at a clock edge raises `s_valid` in the next cycle. After a completed transfer, `s_valid` is low for one cycle before the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 3 | Request per master, held until acknowledged |
| m_addr | input | 96 | Packed 32-bit address per master |
| m_we | input | 3 | Write flag per master |
| m_wdata | input | 96 | Packed 32-bit write data per master |
| m_boost | input | 3 | Priority elevation per master |
| m_ack | output | 3 | Transfer done per master |
| m_err | output | 3 | Error acknowledge for unmapped addresses |
| m_rdata | output | 96 | Packed read data returned to each master |
| s_valid | output | 3 | Transfer presented to each target |
| s_addr | output | 96 | Packed address to each target |
| s_we | output | 3 | Write flag to each target |
| s_wdata | output | 96 | Packed write data to each target |
| s_ready | input | 3 | Target completes its transfer |
| s_rdata | input | 96 | Packed read data from each target |

## Verification
The hardest case to reach is a boost decision. To test it, two or three masters must land on the same idle target in the same cycle with mixed boost values. A boosted latecomer must also queue behind an owner whose target is stalled. Directed cases set up these collisions explicitly. A long random phase then adds them in bulk: requests pile up behind targets whose ready line is withheld on about a third of the cycles. At every grant, the bench recomputes the expected winner from the request and boost values seen at the preceding edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_MASTERS = 3;
  localparam int XB_SLAVES  = 3;
  localparam int XB_AW      = 32;
  localparam int XB_DW      = 32;
  localparam int XB_TAG_W   = 4;
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int NS    = 3,
  parameter int TAG_W = 4,
  parameter logic [NS*TAG_W-1:0] TAGS = '0
) (
  input  logic [TAG_W-1:0] tag,
  output logic [NS-1:0]    hit,
  output logic             miss
);
  for (genvar k = 0; k < NS; k++) begin : g_win
    assign hit[k] = (tag == TAGS[k*TAG_W +: TAG_W]);
  end
  assign miss = ~|hit;
endmodule

// File: rtl/xbar_arb.sv
module xbar_arb #(
  parameter int NM = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NM-1:0]     want,
  input  logic [NM-1:0]     boost,
  input  logic [NM*AW-1:0]  m_addr,
  input  logic [NM-1:0]     m_we,
  input  logic [NM*DW-1:0]  m_wdata,
  input  logic              s_ready,
  output logic              s_valid,
  output logic [AW-1:0]     s_addr,
  output logic              s_we,
  output logic [DW-1:0]     s_wdata,
  output logic [NM-1:0]     grant
);
  logic          busy;
  logic [NM-1:0] own;
  logic [NM-1:0] elev, pool, pick;

  // boosted contenders form the pool if any exist; lowest index wins
  assign elev = want & boost;
  assign pool = (|elev) ? elev : want;
  assign pick = pool & (~pool + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      own  <= '0;
    end else if (!busy) begin
      if (|want) begin
        busy <= 1'b1;
        own  <= pick;
      end
    end else if (s_ready) begin
      busy <= 1'b0;
    end
  end

  assign s_valid = busy;
  assign grant   = busy ? own : '0;

  always_comb begin
    s_addr  = '0;
    s_we    = 1'b0;
    s_wdata = '0;
    for (int i = 0; i < NM; i++) begin
      if (grant[i]) begin
        s_addr  = s_addr  | m_addr[i*AW +: AW];
        s_we    = s_we    | m_we[i];
        s_wdata = s_wdata | m_wdata[i*DW +: DW];
      end
    end
  end

  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (rst)
    busy && !s_ready |=> busy && $stable(own)); // R6
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> |(own & $past(want))); // R9
  AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) && !(|$past(want & boost)) |-> (($past(want) & (own - 1'b1)) == '0)); // R4
  AST_BOOST_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) && (|$past(want & boost)) |-> |(own & $past(boost))); // R5
  AST_FREE_GAP: assert property (@(posedge clk) disable iff (rst)
    busy && s_ready |=> !busy); // R9
endmodule

// File: rtl/xbar3_top.sv
module xbar3_top
  import xbar_pkg::*;
#(
  parameter int NM    = XB_MASTERS,
  parameter int NS    = XB_SLAVES,
  parameter int AW    = XB_AW,
  parameter int DW    = XB_DW,
  parameter int TAG_W = XB_TAG_W,
  parameter logic [NS*TAG_W-1:0] SLV_TAGS = {4'hC, 4'h4, 4'h0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NM-1:0]     m_req,
  input  logic [NM*AW-1:0]  m_addr,
  input  logic [NM-1:0]     m_we,
  input  logic [NM*DW-1:0]  m_wdata,
  input  logic [NM-1:0]     m_boost,
  output logic [NM-1:0]     m_ack,
  output logic [NM-1:0]     m_err,
  output logic [NM*DW-1:0]  m_rdata,
  output logic [NS-1:0]     s_valid,
  output logic [NS*AW-1:0]  s_addr,
  output logic [NS-1:0]     s_we,
  output logic [NS*DW-1:0]  s_wdata,
  input  logic [NS-1:0]     s_ready,
  input  logic [NS*DW-1:0]  s_rdata
);
  logic [NS-1:0] hit [NM];
  logic [NM-1:0] miss;
  logic [NM-1:0] want  [NS];
  logic [NM-1:0] grant [NS];
  logic [NM-1:0] err_q;

  for (genvar j = 0; j < NM; j++) begin : g_mst
    xbar_decode #(.NS(NS), .TAG_W(TAG_W), .TAGS(SLV_TAGS)) u_dec (
      .tag  (m_addr[j*AW + AW - 1 -: TAG_W]),
      .hit  (hit[j]),
      .miss (miss[j])
    );
  end

  // unmapped requests answered by a one-cycle error register
  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= m_req & miss & ~err_q;
  end

  always_comb begin
    for (int k = 0; k < NS; k++) begin
      for (int j = 0; j < NM; j++) want[k][j] = m_req[j] & hit[j][k];
    end
  end

  for (genvar k = 0; k < NS; k++) begin : g_slv
    xbar_arb #(.NM(NM), .AW(AW), .DW(DW)) u_arb (
      .clk     (clk),
      .rst     (rst),
      .want    (want[k]),
      .boost   (m_boost),
      .m_addr  (m_addr),
      .m_we    (m_we),
      .m_wdata (m_wdata),
      .s_ready (s_ready[k]),
      .s_valid (s_valid[k]),
      .s_addr  (s_addr[k*AW +: AW]),
      .s_we    (s_we[k]),
      .s_wdata (s_wdata[k*DW +: DW]),
      .grant   (grant[k])
    );
  end

  logic [NS-1:0] route [NM];
  always_comb begin
    m_rdata = '0;
    for (int j = 0; j < NM; j++) begin
      m_ack[j] = err_q[j];
      for (int k = 0; k < NS; k++) begin
        route[j][k] = grant[k][j];
        if (grant[k][j]) begin
          m_ack[j] = m_ack[j] | s_ready[k];
          m_rdata[j*DW +: DW] = m_rdata[j*DW +: DW] | s_rdata[k*DW +: DW];
        end
      end
    end
  end
  assign m_err = err_q;

  for (genvar j = 0; j < NM; j++) begin : g_chk
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      m_ack[j] |-> m_req[j]); // R8
    AST_ERR_NO_ROUTE: assert property (@(posedge clk) disable iff (rst)
      m_err[j] |-> (route[j] == '0)); // R3
    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(route[j])); // R7
  end
endmodule

// File: tb/xbar3_top_tb_top.sv
`timescale 1ns/1ps
module xbar3_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]  m_req = '0, m_we = '0, m_boost = '0;
  logic [95:0] m_addr = '0, m_wdata = '0;
  logic [2:0]  m_ack, m_err, s_valid, s_we;
  logic [95:0] m_rdata, s_addr, s_wdata, s_rdata;
  logic [2:0]  s_ready = '0;

  xbar3_top dut_i (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_we(m_we),
    .m_wdata(m_wdata), .m_boost(m_boost), .m_ack(m_ack), .m_err(m_err),
    .m_rdata(m_rdata), .s_valid(s_valid), .s_addr(s_addr), .s_we(s_we),
    .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata)
  );

  for (genvar k = 0; k < 3; k++) begin : g_sm
    assign s_rdata[k*32 +: 32] = s_addr[k*32 +: 32] ^ 32'h5A00_0000 ^ 32'(k);
  end

  int total = 0, bad = 0;
  bit rnd_on = 0;
  bit acked [3];
  bit preq [3];
  int age [3];
  int pred [3];
  bit predb [3];
  bit pv [3], pr [3];
  logic [31:0] pa [3];
  int first_free = 0;

  function automatic int tgt(input logic [31:0] a);
    case (a[31:28])
      4'h0: return 0;
      4'h4: return 1;
      4'hC: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int winner(input logic [2:0] rq, input logic [2:0] bo);
    logic [2:0] p;
    p = ((rq & bo) != 0) ? (rq & bo) : rq;
    for (int i = 0; i < 3; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] sa(input int k); return s_addr[k*32 +: 32]; endfunction
  function automatic logic [31:0] ma(input int j); return m_addr[j*32 +: 32]; endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // port-level checker
  always @(negedge clk) begin
    if (rst || first_free == 0) begin
      chk(s_valid == 0 && m_ack == 0, "R1 quiet", {s_valid, m_ack}, 0);
      for (int k = 0; k < 3; k++) begin pred[k] = -1; pv[k] = 0; pr[k] = 0; end
      for (int j = 0; j < 3; j++) begin acked[j] = 0; preq[j] = 0; age[j] = 0; end
      if (!rst) first_free = 1;
    end else begin
      for (int k = 0; k < 3; k++) begin
        int own;
        logic [2:0] rq;
        own = -1;
        rq = '0;
        for (int j = 0; j < 3; j++) begin
          if (m_req[j] && tgt(ma(j)) == k) begin
            rq[j] = 1'b1;
            if (ma(j) == sa(k)) own = j;
          end
        end
        if (s_valid[k]) begin
          chk(own >= 0, "R2 owner addr", sa(k), 0);
          if (own >= 0)
            chk(s_we[k] == m_we[own] && s_wdata[k*32 +: 32] == m_wdata[own*32 +: 32],
                "R2 forward", s_wdata[k*32 +: 32], m_wdata[own*32 +: 32]);
        end
        if (pred[k] >= 0)
          chk(s_valid[k] && own == pred[k], predb[k] ? "R5 boost winner" : "R4 fixed winner/R9",
              own, pred[k]);
        if (pv[k] && !pr[k]) chk(s_valid[k] && sa(k) == pa[k], "R6 hold", sa(k), pa[k]);
        if (pv[k] && pr[k]) chk(!s_valid[k], "R9 gap", s_valid[k], 0);
        pred[k] = -1;
        if (!s_valid[k] && rq != 0) begin
          pred[k] = winner(rq, m_boost);
          predb[k] = (rq & m_boost) != 0;
        end
        pv[k] = s_valid[k]; pr[k] = s_ready[k]; pa[k] = sa(k);
      end
      for (int j = 0; j < 3; j++) begin
        int t;
        t = tgt(ma(j));
        if (m_req[j]) age[j] = (acked[j] || !preq[j]) ? 1 : age[j] + 1;
        if (m_ack[j]) begin
          if (t == 3) chk(m_err[j] && age[j] == 2, "R3 error ack", age[j], 2);
          else chk(!m_err[j] && s_valid[t] && s_ready[t] && sa(t) == ma(j) &&
                   m_rdata[j*32 +: 32] == (ma(j) ^ 32'h5A00_0000 ^ 32'(t)),
                   "R8 response", m_rdata[j*32 +: 32], ma(j) ^ 32'h5A00_0000 ^ 32'(t));
        end else if (m_req[j] && t < 3 && s_valid[t] && s_ready[t] && sa(t) == ma(j)) begin
          chk(0, "R8 missing ack", 0, 1);
        end
        preq[j] = m_req[j];
        acked[j] = m_ack[j];
      end
    end
  end

  task automatic issue(input int j, input logic [31:0] a, input bit b);
    m_req[j] = 1'b1;
    m_addr[j*32 +: 32] = a;
    m_we[j] = a[2];
    m_wdata[j*32 +: 32] = ~a;
    m_boost[j] = b;
  endtask

  // master release / random traffic
  always @(posedge clk) begin
    #1;
    for (int j = 0; j < 3; j++) begin
      if (acked[j]) m_req[j] = 1'b0;
      if (rnd_on && !m_req[j] && ($urandom % 3 == 0)) begin
        logic [3:0] tg;
        case ($urandom % 7)
          0, 1: tg = 4'h0;
          2, 3: tg = 4'h4;
          4, 5: tg = 4'hC;
          default: tg = 4'h8;
        endcase
        issue(j, {tg, 26'($urandom), 2'(j)}, ($urandom % 4) == 0);
      end
    end
    if (rnd_on) for (int k = 0; k < 3; k++) s_ready[k] = ($urandom % 3) != 0;
  end

  task automatic settle();
    for (int n = 0; n < 40 && m_req != 0; n++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    s_ready = 3'b111;
    repeat (3) @(negedge clk);

    // R4: three masters collide at SRAM
    @(posedge clk); #2;
    issue(0, 32'h4000_0100, 0); issue(1, 32'h4000_0201, 0); issue(2, 32'h4000_0302, 0);
    @(negedge clk); @(negedge clk);
    chk(s_valid[1] && sa(1) == 32'h4000_0100, "R4 data first", sa(1), 32'h4000_0100);
    @(negedge clk); @(negedge clk);
    chk(s_valid[1] && sa(1) == 32'h4000_0201, "R4 inst second", sa(1), 32'h4000_0201);
    settle();

    // R5: DMA boosted beats both
    @(posedge clk); #2;
    issue(0, 32'h4000_0400, 0); issue(1, 32'h4000_0501, 0); issue(2, 32'h4000_0602, 1);
    @(negedge clk); @(negedge clk);
    chk(s_valid[1] && sa(1) == 32'h4000_0602, "R5 dma boosted", sa(1), 32'h4000_0602);
    settle();

    // R5: boosted tie resolved by fixed order
    @(posedge clk); #2;
    issue(0, 32'h4000_0700, 0); issue(1, 32'h4000_0801, 1); issue(2, 32'h4000_0902, 1);
    @(negedge clk); @(negedge clk);
    chk(s_valid[1] && sa(1) == 32'h4000_0801, "R5 boosted tie", sa(1), 32'h4000_0801);
    settle();

    // R7: three disjoint targets in parallel
    @(posedge clk); #2;
    issue(0, 32'h0000_0a00, 0); issue(1, 32'h4000_0b01, 0); issue(2, 32'hC000_0c02, 0);
    @(negedge clk); @(negedge clk);
    chk(s_valid == 3'b111 && m_ack == 3'b111, "R7 parallel", {s_valid, m_ack}, 6'h3F);
    settle();

    // R3: unmapped address
    @(posedge clk); #2;
    issue(0, 32'h8000_0d00, 0);
    @(negedge clk);
    chk(!m_ack[0] && s_valid == 0, "R3 not yet", m_ack[0], 0);
    @(negedge clk);
    chk(m_ack[0] && m_err[0] && s_valid == 0, "R3 error now", {m_ack[0], m_err[0]}, 2'b11);
    settle();

    // R6: stalled SRAM keeps owner; boosted DMA waits
    s_ready[1] = 1'b0;
    @(posedge clk); #2;
    issue(0, 32'h4000_0e00, 0);
    @(posedge clk); #2;
    issue(2, 32'h4000_0f02, 1);
    repeat (5) @(negedge clk);
    chk(s_valid[1] && sa(1) == 32'h4000_0e00 && !m_ack[2], "R6 stalled owner", sa(1), 32'h4000_0e00);
    @(posedge clk); #2 s_ready[1] = 1'b1;
    settle();

    // random phase
    rnd_on = 1;
    repeat (20000) @(posedge clk);
    rnd_on = 0;
    @(posedge clk); #2 s_ready = 3'b111;
    repeat (40) @(negedge clk);
    chk(m_req == 0 && s_valid == 0, "R8 drained", {m_req, s_valid}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule